// File: doc/BRIEF.md
# Debug Cross-Trigger Channel Interface

This block sits beside one processor core and connects the core's debug trigger lines to a small set of event channels that are shared across the system. A debug agent reaches it through a simple valid/ready register bus. Through that bus it can raise a channel for a single cycle, hold a channel active, or release a held channel. Each core-side trigger output has its own channel mask. A trigger output latches when any channel in its mask becomes active. Output 0 requests a halt and output 1 requests a restart.

Channels arrive from the wider cross-trigger matrix on an input port. They are combined with the locally driven channels before the masks are applied. Channels that are driven locally leave toward the matrix only through a per-channel gate, and a closed gate does not stop local triggering. A latched trigger output stays high until software acknowledges it. A global enable bit masks every trigger output and every outgoing channel.

A typical resume sequence closes the gate, sets the enable bit, routes channel 0 to output 1, and pulses channel 0. The agent then polls the core and acknowledges the restart trigger.

Top module: `crossTrigUnit`

## Requirements
- R1: After reset the enable bit reads 0, every mask word reads 0, no trigger output is latched, and the gate register (offset 0x140) reads all ones, one bit per channel.
- R2: Every request accepted while reqValid and reqReady are both high is answered by rspValid in the following cycle. A read returns the addressed register zero-extended. Write-only offsets, unmapped offsets and unused bits read as 0.
- R3: Bit 0 at offset 0x000 is the global enable. While it is 0, no trigger output and no outgoing channel asserts, and no new trigger is latched.
- R4: Writing a 1 to bit c at offset 0x01C makes channel c active for exactly one cycle, starting in the cycle after the write is accepted.
- R5: Writing a 1 to bit c at offset 0x014 holds channel c active. Writing a 1 to bit c at offset 0x018 releases it. Offset 0x014 reads back the set of held channels.
- R6: The mask word for trigger output n is at offset 0x0A0 + 4*n, with bit c selecting channel c. Output n latches in the cycle after any selected channel is active. Output 0 drives haltReq and output 1 drives restartReq.
- R7: A latched trigger output stays high until a 1 is written to its bit at offset 0x010. If a selected channel is still active in the same cycle as the acknowledge, the output stays latched.
- R8: A 0 in bit c of the gate register blocks local activity on channel c from reaching chOut, while local triggering from that channel still works.
- R9: Activity on chIn is combined by OR with the local channels before the masks are applied, and it is never echoed on chOut.
- R10: Offset 0x130 reads the current trigger output vector, one bit per output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Register request valid |
| reqReady | output | 1 | Request accepted (always ready) |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 12 | Byte offset, word aligned |
| reqWdata | input | 32 | Write data |
| rspValid | output | 1 | Response for the previous accepted request |
| rspRdata | output | 32 | Read data (0 for writes) |
| chIn | input | 4 | Channel events from the matrix |
| chOut | output | 4 | Gated local channel events toward the matrix |
| trigOut | output | 8 | Latched trigger outputs |
| haltReq | output | 1 | Trigger output 0 |
| restartReq | output | 1 | Trigger output 1 |

## Verification
The main routing is swept over every channel and trigger pair twice. The first pass uses a mask holding only the pulsed channel, which shows that the right output latches and no other does. The second pass uses a mask holding every channel except the pulsed one, which exposes leakage between channels and between mask bits. Held channels are tested apart from single pulses, which separates the one-cycle pulse from the sticky latch, and they are also used to show that an acknowledge loses to a live channel. Matrix input, closed gates and a cleared enable are each applied against masks that would otherwise fire. This separates routing from the gating toward the matrix and from the global masking.

// File: rtl/ctiPkg.sv
package ctiPkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_ACK    = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_SET    = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_CLR    = 12'h018;
  localparam logic [ADDR_W-1:0] OFS_PULSE  = 12'h01C;
  localparam logic [ADDR_W-1:0] OFS_OUTEN  = 12'h0A0;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 12'h130;
  localparam logic [ADDR_W-1:0] OFS_GATE   = 12'h140;

  typedef enum logic [2:0] {
    RD_NONE, RD_CTRL, RD_SET, RD_OUTEN, RD_STATUS, RD_GATE
  } ctiRdSrc_e;

  typedef struct packed {
    logic              wrCtrl;
    logic              wrAck;
    logic              wrSet;
    logic              wrClear;
    logic              wrPulse;
    logic              wrOutEn;
    logic              wrGate;
    logic [7:0]        idx;
    logic [DATA_W-1:0] wdata;
  } ctiStrobes_t;

  typedef struct packed {
    ctiRdSrc_e  src;
    logic [7:0] idx;
  } ctiRdSel_t;
endpackage

// File: rtl/ctiRegCtrl.sv
module ctiRegCtrl
  import ctiPkg::*;
#(
  parameter int NUM_TRIG = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output ctiStrobes_t       strb,
  output ctiRdSel_t         rdSel,
  input  logic [DATA_W-1:0] rdValue
);
  localparam logic [ADDR_W-1:0] OUTEN_END = ADDR_W'(int'(OFS_OUTEN) + 4 * NUM_TRIG);

  logic              accept;
  logic              aligned;
  logic              inOutEn;
  logic [ADDR_W-1:0] outEnDelta;
  logic              wrAcc;

  assign reqReady   = 1'b1;
  assign accept     = reqValid && reqReady;
  assign wrAcc      = accept && reqWrite;
  assign aligned    = (reqAddr[1:0] == 2'b00);
  assign outEnDelta = reqAddr - OFS_OUTEN;
  assign inOutEn    = aligned && (reqAddr >= OFS_OUTEN) && (reqAddr < OUTEN_END);

  always_comb begin
    strb         = '0;
    strb.wdata   = reqWdata;
    strb.idx     = outEnDelta[9:2];
    if (wrAcc && aligned) begin
      strb.wrCtrl  = (reqAddr == OFS_CTRL);
      strb.wrAck   = (reqAddr == OFS_ACK);
      strb.wrSet   = (reqAddr == OFS_SET);
      strb.wrClear = (reqAddr == OFS_CLR);
      strb.wrPulse = (reqAddr == OFS_PULSE);
      strb.wrGate  = (reqAddr == OFS_GATE);
      strb.wrOutEn = inOutEn;
    end
  end

  always_comb begin
    rdSel.idx = outEnDelta[9:2];
    rdSel.src = RD_NONE;
    if (aligned) begin
      if (reqAddr == OFS_CTRL)        rdSel.src = RD_CTRL;
      else if (reqAddr == OFS_SET)    rdSel.src = RD_SET;
      else if (reqAddr == OFS_STATUS) rdSel.src = RD_STATUS;
      else if (reqAddr == OFS_GATE)   rdSel.src = RD_GATE;
      else if (inOutEn)               rdSel.src = RD_OUTEN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspRdata <= '0;
    end else begin
      rspValid <= accept;
      rspRdata <= (accept && !reqWrite) ? rdValue : '0;
    end
  end

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid));
endmodule

// File: rtl/ctiDatapath.sv
module ctiDatapath
  import ctiPkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int NUM_TRIG = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctiStrobes_t         strb,
  input  ctiRdSel_t           rdSel,
  output logic [DATA_W-1:0]   rdValue,
  input  logic [NUM_CH-1:0]   chIn,
  output logic [NUM_CH-1:0]   chOut,
  output logic [NUM_TRIG-1:0] trigOut
);
  localparam int IDX_W = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;

  logic                enable;
  logic [NUM_CH-1:0]   setReg;
  logic [NUM_CH-1:0]   pulseQ;
  logic [NUM_CH-1:0]   gateReg;
  logic [NUM_CH-1:0]   outEn [NUM_TRIG];
  logic [NUM_TRIG-1:0] trigLatch;
  logic [NUM_CH-1:0]   localCh;
  logic [NUM_CH-1:0]   activeCh;
  logic [NUM_TRIG-1:0] hit;
  logic [NUM_TRIG-1:0] ackMask;
  logic [NUM_CH-1:0]   wCh;
  logic [IDX_W-1:0]    rdIdx;
  logic                unusedBits;

  assign wCh        = strb.wdata[NUM_CH-1:0];
  assign ackMask    = strb.wrAck ? strb.wdata[NUM_TRIG-1:0] : '0;
  assign rdIdx      = rdSel.idx[IDX_W-1:0];
  assign unusedBits = ^{strb.wdata, strb.idx, rdSel.idx};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable  <= 1'b0;
      setReg  <= '0;
      pulseQ  <= '0;
      gateReg <= '1;
    end else begin
      if (strb.wrCtrl) enable <= strb.wdata[0];
      if (strb.wrGate) gateReg <= wCh;
      setReg <= (setReg | (strb.wrSet ? wCh : '0)) & ~(strb.wrClear ? wCh : '0);
      pulseQ <= strb.wrPulse ? wCh : '0;
    end
  end

  assign localCh  = setReg | pulseQ;
  assign activeCh = localCh | chIn;
  assign chOut    = localCh & gateReg & {NUM_CH{enable}};

  for (genvar n = 0; n < NUM_TRIG; n++) begin : gTrig
    assign hit[n] = |(outEn[n] & activeCh);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        outEn[n]     <= '0;
        trigLatch[n] <= 1'b0;
      end else begin
        if (strb.wrOutEn && (strb.idx == 8'(n))) outEn[n] <= wCh;
        trigLatch[n] <= (trigLatch[n] && !ackMask[n]) || (enable && hit[n]);
      end
    end
  end

  assign trigOut = trigLatch & {NUM_TRIG{enable}};

  always_comb begin
    rdValue = '0;
    case (rdSel.src)
      RD_CTRL:   rdValue[0] = enable;
      RD_SET:    rdValue[NUM_CH-1:0] = setReg;
      RD_GATE:   rdValue[NUM_CH-1:0] = gateReg;
      RD_OUTEN:  rdValue[NUM_CH-1:0] = outEn[rdIdx];
      RD_STATUS: rdValue[NUM_TRIG-1:0] = trigOut;
      default:   rdValue = '0;
    endcase
  end

  // R4
  pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((pulseQ != '0) && !strb.wrPulse) |=> (pulseQ == '0));

  // R7
  latch_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(trigLatch & ~ackMask)) |=> ((trigLatch & $past(trigLatch & ~ackMask)) == $past(trigLatch & ~ackMask)));

  // R7
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|(ackMask & ~hit)) |=> ((trigLatch & $past(ackMask & ~hit)) == '0));

  // R3
  no_latch_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (trigLatch == $past(trigLatch & ~ackMask)));
endmodule

// File: rtl/crossTrigUnit.sv
module crossTrigUnit
  import ctiPkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int NUM_TRIG = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  output logic                rspValid,
  output logic [DATA_W-1:0]   rspRdata,
  input  logic [NUM_CH-1:0]   chIn,
  output logic [NUM_CH-1:0]   chOut,
  output logic [NUM_TRIG-1:0] trigOut,
  output logic                haltReq,
  output logic                restartReq
);
  ctiStrobes_t       strb;
  ctiRdSel_t         rdSel;
  logic [DATA_W-1:0] rdValue;

  ctiRegCtrl #(.NUM_TRIG(NUM_TRIG)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata),
    .strb(strb), .rdSel(rdSel), .rdValue(rdValue)
  );

  ctiDatapath #(.NUM_CH(NUM_CH), .NUM_TRIG(NUM_TRIG)) u_dp (
    .clk(clk), .rstN(rstN),
    .strb(strb), .rdSel(rdSel), .rdValue(rdValue),
    .chIn(chIn), .chOut(chOut), .trigOut(trigOut)
  );

  assign haltReq    = trigOut[0];
  assign restartReq = trigOut[1];
endmodule

// File: tb/crossTrigUnit_tb.sv
module crossTrigUnit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int NTRIG = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [11:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        rspValid;
  logic [31:0] rspRdata;
  logic [3:0]  chIn = '0;
  logic [3:0]  chOut;
  logic [7:0]  trigOut;
  logic        haltReq;
  logic        restartReq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [31:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  crossTrigUnit u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata), .chIn(chIn), .chOut(chOut),
    .trigOut(trigOut), .haltReq(haltReq), .restartReq(restartReq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
    check("R2 rspValid", {31'b0, rspValid}, 32'd1);
    d = rspRdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    check("R1 trigOut", {24'b0, trigOut}, 32'h0);
    busRead(12'h000, rd); check("R1 enable", rd, 32'h0);
    busRead(12'h140, rd); check("R1 gate", rd, 32'hF);
    for (int n = 0; n < NTRIG; n++) begin
      busRead(12'(12'h0A0 + 4*n), rd); check("R1 mask", rd, 32'h0);
    end

    // R3 disabled: nothing asserts
    for (int n = 0; n < NTRIG; n++) busWrite(12'(12'h0A0 + 4*n), 32'hF);
    busWrite(12'h014, 32'hF);
    busWrite(12'h01C, 32'hF);
    check("R3 chOut disabled", {28'b0, chOut}, 32'h0);
    repeat (2) @(negedge clk);
    check("R3 trigOut disabled", {24'b0, trigOut}, 32'h0);
    busWrite(12'h018, 32'hF);
    busWrite(12'h000, 32'h1);
    check("R3 no stale latch", {24'b0, trigOut}, 32'h0);
    for (int n = 0; n < NTRIG; n++) busWrite(12'(12'h0A0 + 4*n), 32'h0);

    // R2 readback, unused bits, write-only and unmapped
    busWrite(12'h0A8, 32'hFFFF_FFF5);
    busRead(12'h0A8, rd); check("R2 mask readback", rd, 32'h5);
    busWrite(12'h0A8, 32'h0);
    busRead(12'h000, rd); check("R2 ctrl readback", rd, 32'h1);
    busRead(12'h01C, rd); check("R2 pulse reads 0", rd, 32'h0);
    busRead(12'h010, rd); check("R2 ack reads 0", rd, 32'h0);
    busRead(12'h200, rd); check("R2 unmapped", rd, 32'h0);

    // R6 sweep over channel/trigger pairs
    for (int c = 0; c < NCH; c++) begin
      for (int t = 0; t < NTRIG; t++) begin
        busWrite(12'(12'h0A0 + 4*t), 32'(1 << c));
        busWrite(12'h01C, 32'(1 << c));
        check("R4 pulse on chOut", {28'b0, chOut}, 32'(1 << c));
        @(negedge clk);
        check("R4 pulse ended", {28'b0, chOut}, 32'h0);
        check("R6 single mask", {24'b0, trigOut}, 32'(1 << t));
        busWrite(12'h010, 32'hFF);
        check("R7 ack clears", {24'b0, trigOut}, 32'h0);
        busWrite(12'(12'h0A0 + 4*t), 32'(4'hF & ~(4'(1) << c)));
        busWrite(12'h01C, 32'(1 << c));
        @(negedge clk);
        check("R6 other mask", {24'b0, trigOut}, 32'h0);
        busWrite(12'(12'h0A0 + 4*t), 32'h0);
      end
    end

    // R6 restart from channel 0, R7 sticky, R10 status
    busWrite(12'h0A4, 32'h1);
    busWrite(12'h01C, 32'h1);
    repeat (6) @(negedge clk);
    check("R6 restartReq", {31'b0, restartReq}, 32'h1);
    check("R6 haltReq", {31'b0, haltReq}, 32'h0);
    check("R7 sticky", {24'b0, trigOut}, 32'h2);
    busRead(12'h130, rd); check("R10 status", rd, 32'h2);
    busWrite(12'h010, 32'h2);
    busRead(12'h130, rd); check("R10 status acked", rd, 32'h0);
    busWrite(12'h0A4, 32'h0);

    // R5 held channel, R7 ack loses to live channel
    busWrite(12'h0AC, 32'h4);
    busWrite(12'h014, 32'h4);
    busRead(12'h014, rd); check("R5 held readback", rd, 32'h4);
    check("R5 held chOut", {28'b0, chOut}, 32'h4);
    busWrite(12'h010, 32'h8);
    check("R7 ack vs live", {24'b0, trigOut}, 32'h8);
    busWrite(12'h018, 32'h4);
    check("R5 released", {28'b0, chOut}, 32'h0);
    busWrite(12'h010, 32'h8);
    check("R7 ack after release", {24'b0, trigOut}, 32'h0);
    busWrite(12'h0AC, 32'h0);

    // R8 closed gate
    busWrite(12'h140, 32'hE);
    busRead(12'h140, rd); check("R8 gate readback", rd, 32'hE);
    busWrite(12'h0A4, 32'h1);
    busWrite(12'h01C, 32'h1);
    check("R8 gated chOut", {28'b0, chOut}, 32'h0);
    @(negedge clk);
    check("R8 local restart", {31'b0, restartReq}, 32'h1);
    busWrite(12'h010, 32'hFF);
    busWrite(12'h0A4, 32'h0);
    busWrite(12'h140, 32'hF);

    // R9 matrix input
    busWrite(12'h0A0, 32'h2);
    chIn = 4'h2;
    @(negedge clk);
    check("R9 no echo", {28'b0, chOut}, 32'h0);
    chIn = 4'h0;
    @(negedge clk);
    check("R9 halt from chIn", {31'b0, haltReq}, 32'h1);
    busWrite(12'h010, 32'h1);
    check("R9 acked", {24'b0, trigOut}, 32'h0);

    // R3 enable cleared masks a latched output
    busWrite(12'h01C, 32'h2);
    @(negedge clk);
    busWrite(12'h000, 32'h0);
    check("R3 masked latch", {24'b0, trigOut}, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule